// File: doc/BRIEF.md
# Prioritized CPU Interrupt Entry Controller

This block decides when a CPU core takes an exception and carries out the entry. It sits between an external interrupt controller and the core. It watches three request sources: a reset request, a non-maskable request, and a 3-bit pending priority level. It reads the core's program counter, status word and stack pointer. When it accepts a request, it pushes the return address and the status word onto the stack through a valid/ready memory write port. After both pushes are accepted, it hands the core a new program counter, status word and stack pointer in a single update cycle.

The status word has an interrupt-enable flag at bit 11 and a 3-bit level mask at bits 10:8. A level interrupt is taken only when interrupts are enabled and the pending level is strictly below the mask. The handler address is a fixed high base plus a 16-bit offset held in a per-level vector register. These vector registers sit in a small register window on a 16-bit little-endian bus, next to two read-only identification words.

A reset request is not an entry. The block reports it with a one-cycle pulse, so the surrounding system can restart the core.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After reset the block is idle: no memory write is requested, and no update, acknowledge or reset pulse is given. Every vector register reads 0, and the pending level counts as 7 (nothing pending).
- R2: Requests are served one per decision in fixed priority: reset before non-maskable, and non-maskable before level. A served reset gives a one-cycle pulse on `rst_take_o`, performs no stack writes and leaves a lower request waiting.
- R3: A level request is accepted only when status bit 11 is 1 and the level is numerically smaller than status bits 10:8. Level 7 is never accepted.
- R4: An entry issues two stack writes in this order. The first is the 32-bit return PC at SP-4, with `mw_word_o`=1. The second is the status word, zero-extended, at SP-8, with `mw_word_o`=0. Each write is held stable until `mw_ready_i` is seen.
- R5: A level entry sets PC to 0x40000000 plus that level's 16-bit vector. It clears status bit 11, writes the level into bits 10:8, keeps all other status bits, and lowers SP by 8.
- R6: A non-maskable entry sets PC to 0x40000008, clears status bit 11, leaves bits 10:8 and the other status bits unchanged, and lowers SP by 8.
- R7: `ack_valid_o` pulses with the accepted level on `ack_level_o`, in the update cycle, only for level entries.
- R8: The reset and non-maskable inputs are captured on a rising edge and cleared when served. An input held high gives exactly one service.
- R9: On the register bus, vector n reads at byte offset 4n (n = 0..6). Offset 0x20 reads the MEMCTL_VAL parameter, offset 0x40 reads the CPUMODE_VAL parameter, and every other offset reads 0.
- R10: A write takes effect only when it is exactly 2 bytes wide (`reg_size_i`=2) and aimed at a vector register. Any other write changes nothing.
- R11: `upd_o` is raised for one cycle, in the cycle after the status push is accepted, and never before both pushes are accepted.
- R12: The pending level is re-evaluated every idle cycle. A level that becomes acceptable later, because the status changes, is taken. A level withdrawn (set to 7) before it becomes acceptable is never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_req_i | input | 1 | Reset request (rising edge captured) |
| nmi_i | input | 1 | Non-maskable request (rising edge captured) |
| level_i | input | 3 | Pending priority level, 7 = none |
| pc_i | input | 32 | Core program counter |
| psw_i | input | 16 | Core status word |
| sp_i | input | 32 | Core stack pointer |
| upd_o | output | 1 | Core state update strobe |
| pc_o | output | 32 | New program counter |
| psw_o | output | 16 | New status word |
| sp_o | output | 32 | New stack pointer |
| mw_valid_o | output | 1 | Stack write request |
| mw_ready_i | input | 1 | Stack write accepted |
| mw_addr_o | output | 32 | Stack write byte address |
| mw_data_o | output | 32 | Stack write data |
| mw_word_o | output | 1 | 1 = 32-bit write, 0 = 16-bit write |
| ack_valid_o | output | 1 | Level acknowledge pulse |
| ack_level_o | output | 3 | Acknowledged level |
| rst_take_o | output | 1 | Reset request served pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_size_i | input | 3 | Write width in bytes |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |

## Verification
A wrong priority or acceptance decision shows at the memory port within three cycles of the request: either a stack write appears where none is due, or none appears where one is due. A corrupted captured context or vector shows at the single update cycle, in the pushed addresses and data and in the new PC, status and SP. A stuck request latch shows as a repeated entry as soon as the core's status allows it. A write decode fault shows at once on the combinational read port.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int LVL_W      = 3;
    localparam int PSW_W      = 16;
    localparam int ADR_W      = 32;
    localparam int VEC_W      = 16;
    localparam int PSW_IE_BIT = 11;
    localparam int PSW_LM_LSB = 8;

    localparam logic [LVL_W-1:0] LVL_IDLE    = '1;
    localparam logic [ADR_W-1:0] VEC_BASE    = 32'h4000_0000;
    localparam logic [ADR_W-1:0] NMI_TARGET  = 32'h4000_0008;
    localparam logic [ADR_W-1:0] FRAME_BYTES = 32'd8;
    localparam logic [ADR_W-1:0] PC_SLOT     = 32'd4;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_RST,
        SRC_NMI,
        SRC_LVL
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_PSW,
        ST_COMMIT
    } seq_st_e;

    typedef struct packed {
        logic [ADR_W-1:0] pc;
        logic [PSW_W-1:0] psw;
        logic [ADR_W-1:0] sp;
    } core_ctx_t;

    typedef struct packed {
        src_e             src;
        logic [LVL_W-1:0] lvl;
    } grant_t;

    function automatic logic [PSW_W-1:0] psw_on_entry(
        input logic [PSW_W-1:0] p,
        input logic             is_lvl,
        input logic [LVL_W-1:0] l
    );
        logic [PSW_W-1:0] r;
        r = p;
        r[PSW_IE_BIT] = 1'b0;
        if (is_lvl) r[PSW_LM_LSB +: LVL_W] = l;
        return r;
    endfunction

    function automatic logic [ADR_W-1:0] vec_target(input logic [VEC_W-1:0] off);
        return VEC_BASE + {{(ADR_W-VEC_W){1'b0}}, off};
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic clr_i,
    output logic pend_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            prev_q <= req_i;
            pend_o <= (pend_o & ~clr_i) | (req_i & ~prev_q);
        end
    end
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs
    import irq_entry_pkg::*;
#(
    parameter int           NUM_VEC     = 7,
    parameter int           REG_AW      = 7,
    parameter logic [15:0]  MEMCTL_VAL  = 16'h0000,
    parameter logic [15:0]  CPUMODE_VAL = 16'h0000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_i,
    input  logic [REG_AW-1:0]        addr_i,
    input  logic [2:0]               size_i,
    input  logic [VEC_W-1:0]         wdata_i,
    output logic [VEC_W-1:0]         rdata_o,
    output logic [NUM_VEC*VEC_W-1:0] vec_flat_o
);
    localparam logic [REG_AW-1:0] OFF_MEMCTL  = REG_AW'(32'h20);
    localparam logic [REG_AW-1:0] OFF_CPUMODE = REG_AW'(32'h40);
    localparam int                STRIDE      = 4;

    logic [VEC_W-1:0] vec_q [NUM_VEC];
    logic             wr_ok;

    assign wr_ok = wr_i && (size_i == 3'd2);

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        always_ff @(posedge clk) begin
            if (rst)
                vec_q[g] <= '0;
            else if (wr_ok && addr_i == REG_AW'(g * STRIDE))
                vec_q[g] <= wdata_i;
        end
        assign vec_flat_o[g*VEC_W +: VEC_W] = vec_q[g];
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_VEC; k++)
            if (addr_i == REG_AW'(k * STRIDE)) rdata_o = vec_q[k];
        if (addr_i == OFF_MEMCTL)  rdata_o = MEMCTL_VAL;
        if (addr_i == OFF_CPUMODE) rdata_o = CPUMODE_VAL;
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_entry_pkg::*;
(
    input  logic             rst_pend_i,
    input  logic             nmi_pend_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             ie_i,
    input  logic [LVL_W-1:0] mask_i,
    output grant_t           grant_o
);
    logic lvl_ok;

    assign lvl_ok = ie_i && (lvl_i != LVL_IDLE) && (lvl_i < mask_i);

    always_comb begin
        grant_o.lvl = lvl_i;
        if (rst_pend_i)      grant_o.src = SRC_RST;
        else if (nmi_pend_i) grant_o.src = SRC_NMI;
        else if (lvl_ok)     grant_o.src = SRC_LVL;
        else                 grant_o.src = SRC_NONE;
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NUM_VEC = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  grant_t                   grant_i,
    input  core_ctx_t                core_i,
    input  logic [NUM_VEC*VEC_W-1:0] vec_flat_i,
    input  logic                     mw_ready_i,
    output logic                     clr_rst_o,
    output logic                     clr_nmi_o,
    output logic                     rst_take_o,
    output logic                     mw_valid_o,
    output logic [ADR_W-1:0]         mw_addr_o,
    output logic [ADR_W-1:0]         mw_data_o,
    output logic                     mw_word_o,
    output logic                     upd_o,
    output logic [ADR_W-1:0]         pc_o,
    output logic [PSW_W-1:0]         psw_o,
    output logic [ADR_W-1:0]         sp_o,
    output logic                     ack_valid_o,
    output logic [LVL_W-1:0]         ack_level_o
);
    seq_st_e          st_q;
    core_ctx_t        ctx_q;
    logic             is_lvl_q;
    logic [LVL_W-1:0] lvl_q;
    logic [VEC_W-1:0] vec_sel;
    logic             idle;

    assign idle      = (st_q == ST_IDLE);
    assign clr_rst_o = idle && grant_i.src == SRC_RST;
    assign clr_nmi_o = idle && grant_i.src == SRC_NMI;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            ctx_q      <= '0;
            is_lvl_q   <= 1'b0;
            lvl_q      <= LVL_IDLE;
            rst_take_o <= 1'b0;
        end else begin
            rst_take_o <= clr_rst_o;
            case (st_q)
                ST_IDLE: begin
                    if (grant_i.src == SRC_NMI || grant_i.src == SRC_LVL) begin
                        ctx_q    <= core_i;
                        is_lvl_q <= (grant_i.src == SRC_LVL);
                        lvl_q    <= grant_i.lvl;
                        st_q     <= ST_PUSH_PC;
                    end
                end
                ST_PUSH_PC:  if (mw_ready_i) st_q <= ST_PUSH_PSW;
                ST_PUSH_PSW: if (mw_ready_i) st_q <= ST_COMMIT;
                default:     st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        vec_sel = '0;
        for (int k = 0; k < NUM_VEC; k++)
            if (lvl_q == LVL_W'(k)) vec_sel = vec_flat_i[k*VEC_W +: VEC_W];
    end

    always_comb begin
        mw_valid_o = 1'b0;
        mw_addr_o  = ctx_q.sp - PC_SLOT;
        mw_data_o  = ctx_q.pc;
        mw_word_o  = 1'b1;
        case (st_q)
            ST_PUSH_PC: mw_valid_o = 1'b1;
            ST_PUSH_PSW: begin
                mw_valid_o = 1'b1;
                mw_addr_o  = ctx_q.sp - FRAME_BYTES;
                mw_data_o  = {{(ADR_W-PSW_W){1'b0}}, ctx_q.psw};
                mw_word_o  = 1'b0;
            end
            default: ;
        endcase
    end

    assign upd_o       = (st_q == ST_COMMIT);
    assign pc_o        = is_lvl_q ? vec_target(vec_sel) : NMI_TARGET;
    assign psw_o       = psw_on_entry(ctx_q.psw, is_lvl_q, lvl_q);
    assign sp_o        = ctx_q.sp - FRAME_BYTES;
    assign ack_valid_o = upd_o && is_lvl_q;
    assign ack_level_o = lvl_q;
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int          NUM_VEC     = 7,
    parameter int          REG_AW      = 7,
    parameter logic [15:0] MEMCTL_VAL  = 16'h0000,
    parameter logic [15:0] CPUMODE_VAL = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req_i,
    input  logic              nmi_i,
    input  logic [2:0]        level_i,
    input  logic [31:0]       pc_i,
    input  logic [15:0]       psw_i,
    input  logic [31:0]       sp_i,
    output logic              upd_o,
    output logic [31:0]       pc_o,
    output logic [15:0]       psw_o,
    output logic [31:0]       sp_o,
    output logic              mw_valid_o,
    input  logic              mw_ready_i,
    output logic [31:0]       mw_addr_o,
    output logic [31:0]       mw_data_o,
    output logic              mw_word_o,
    output logic              ack_valid_o,
    output logic [2:0]        ack_level_o,
    output logic              rst_take_o,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [2:0]        reg_size_i,
    input  logic [15:0]       reg_wdata_i,
    output logic [15:0]       reg_rdata_o
);
    logic                     rst_pend, nmi_pend, clr_rst, clr_nmi;
    logic [LVL_W-1:0]         lvl_q;
    logic [NUM_VEC*VEC_W-1:0] vec_flat;
    grant_t                   grant;
    core_ctx_t                core_ctx;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= LVL_IDLE;
        else     lvl_q <= level_i;
    end

    irq_edge_latch u_rst_latch (
        .clk(clk), .rst(rst), .req_i(rst_req_i), .clr_i(clr_rst), .pend_o(rst_pend)
    );

    irq_edge_latch u_nmi_latch (
        .clk(clk), .rst(rst), .req_i(nmi_i), .clr_i(clr_nmi), .pend_o(nmi_pend)
    );

    irq_arbiter u_arb (
        .rst_pend_i(rst_pend),
        .nmi_pend_i(nmi_pend),
        .lvl_i     (lvl_q),
        .ie_i      (psw_i[PSW_IE_BIT]),
        .mask_i    (psw_i[PSW_LM_LSB +: LVL_W]),
        .grant_o   (grant)
    );

    assign core_ctx = '{pc: pc_i, psw: psw_i, sp: sp_i};

    irq_vec_regs #(
        .NUM_VEC(NUM_VEC), .REG_AW(REG_AW),
        .MEMCTL_VAL(MEMCTL_VAL), .CPUMODE_VAL(CPUMODE_VAL)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
        .size_i(reg_size_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
        .vec_flat_o(vec_flat)
    );

    irq_entry_seq #(.NUM_VEC(NUM_VEC)) u_seq (
        .clk(clk), .rst(rst), .grant_i(grant), .core_i(core_ctx),
        .vec_flat_i(vec_flat), .mw_ready_i(mw_ready_i),
        .clr_rst_o(clr_rst), .clr_nmi_o(clr_nmi), .rst_take_o(rst_take_o),
        .mw_valid_o(mw_valid_o), .mw_addr_o(mw_addr_o), .mw_data_o(mw_data_o),
        .mw_word_o(mw_word_o), .upd_o(upd_o), .pc_o(pc_o), .psw_o(psw_o),
        .sp_o(sp_o), .ack_valid_o(ack_valid_o), .ack_level_o(ack_level_o)
    );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk (
    input logic        clk,
    input logic        rst,
    input logic        mw_valid_o,
    input logic        mw_ready_i,
    input logic        mw_word_o,
    input logic [31:0] mw_addr_o,
    input logic [31:0] mw_data_o,
    input logic        upd_o,
    input logic [15:0] psw_o,
    input logic [31:0] sp_o,
    input logic        ack_valid_o,
    input logic [2:0]  ack_level_o,
    input logic        rst_take_o
);
    AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mw_valid_o && mw_ready_i && mw_word_o) |=> (mw_valid_o && !mw_word_o)); // R4

    AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mw_valid_o && !mw_ready_i) |=> (mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o))); // R4

    AST_UPD_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
        upd_o |-> $past(mw_valid_o && mw_ready_i && !mw_word_o)); // R11

    AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        upd_o |=> !upd_o); // R11

    AST_SP_FRAME: assert property (@(posedge clk) disable iff (rst)
        upd_o |-> (sp_o == $past(mw_addr_o))); // R5

    AST_IE_OFF: assert property (@(posedge clk) disable iff (rst)
        upd_o |-> !psw_o[11]); // R6

    AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ack_valid_o |-> (upd_o && psw_o[10:8] == ack_level_o && ack_level_o != 3'd7)); // R7

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({upd_o, rst_take_o})); // R2
endmodule

bind irq_entry_ctrl irq_entry_chk u_chk (
    .clk(clk), .rst(rst), .mw_valid_o(mw_valid_o), .mw_ready_i(mw_ready_i),
    .mw_word_o(mw_word_o), .mw_addr_o(mw_addr_o), .mw_data_o(mw_data_o),
    .upd_o(upd_o), .psw_o(psw_o), .sp_o(sp_o), .ack_valid_o(ack_valid_o),
    .ack_level_o(ack_level_o), .rst_take_o(rst_take_o)
);

// File: tb/sim_irq_entry_ctrl.sv
module sim_irq_entry_ctrl;
    localparam logic [15:0] MEMCTL  = 16'hA5C3;
    localparam logic [15:0] CPUMODE = 16'h0F1E;

    logic        clk = 0, rst = 1;
    logic        rst_req = 0, nmi = 0;
    logic [2:0]  level = 3'd7;
    logic [31:0] cpc = 0, csp = 0;
    logic [15:0] cpsw = 0;
    logic        upd, mw_valid, mw_ready, mw_word, ackv, rtake;
    logic [31:0] npc, nsp, mw_addr, mw_data;
    logic [15:0] npsw, rdata;
    logic [2:0]  ackl;
    logic        reg_wr = 0;
    logic [6:0]  reg_addr = 0;
    logic [2:0]  reg_size = 0;
    logic [15:0] reg_wdata = 0;

    logic        ld = 0;
    logic [31:0] ld_pc = 0, ld_sp = 0;
    logic [15:0] ld_psw = 0;
    logic        stall = 0;
    int          cyc = 0;

    int          checks = 0, errors = 0;
    int          push_cnt = 0, upd_cnt = 0, ack_cnt = 0, rtake_cnt = 0;
    logic [2:0]  ack_last = 0;
    logic [31:0] lg_addr [8];
    logic [31:0] lg_data [8];
    logic        lg_word [8];
    logic [15:0] vec_m [7];

    always #4 clk = ~clk;

    assign mw_ready = stall ? (cyc % 3 == 2) : 1'b1;

    irq_entry_ctrl #(.MEMCTL_VAL(MEMCTL), .CPUMODE_VAL(CPUMODE)) u0 (
        .clk(clk), .rst(rst), .rst_req_i(rst_req), .nmi_i(nmi), .level_i(level),
        .pc_i(cpc), .psw_i(cpsw), .sp_i(csp), .upd_o(upd), .pc_o(npc),
        .psw_o(npsw), .sp_o(nsp), .mw_valid_o(mw_valid), .mw_ready_i(mw_ready),
        .mw_addr_o(mw_addr), .mw_data_o(mw_data), .mw_word_o(mw_word),
        .ack_valid_o(ackv), .ack_level_o(ackl), .rst_take_o(rtake),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_size_i(reg_size),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (upd) begin
            cpc <= npc; cpsw <= npsw; csp <= nsp;
        end else if (ld) begin
            cpc <= ld_pc; cpsw <= ld_psw; csp <= ld_sp;
        end
        if (mw_valid && mw_ready) begin
            lg_addr[push_cnt % 8] <= mw_addr;
            lg_data[push_cnt % 8] <= mw_data;
            lg_word[push_cnt % 8] <= mw_word;
            push_cnt <= push_cnt + 1;
        end
        if (upd)   upd_cnt <= upd_cnt + 1;
        if (rtake) rtake_cnt <= rtake_cnt + 1;
        if (ackv) begin
            ack_cnt <= ack_cnt + 1; ack_last <= ackl;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_core(input logic [31:0] p, input logic [15:0] s, input logic [31:0] q);
        @(negedge clk);
        ld_pc = p; ld_psw = s; ld_sp = q; ld = 1;
        @(negedge clk);
        ld = 0;
    endtask

    task automatic reg_write(input logic [6:0] a, input logic [2:0] sz, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    // waits for an update; returns whether one came and whether two pushes preceded it
    task automatic wait_entry(input int maxc, output bit got, output int pushes);
        int p0;
        p0 = push_cnt;
        got = 0; pushes = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (upd) begin
                got = 1; pushes = push_cnt - p0;
                break;
            end
        end
        @(negedge clk);
    endtask

    // checks the pushes and new core state of one entry
    task automatic check_frame(input logic [31:0] opc, input logic [15:0] opsw,
                               input logic [31:0] osp, input logic [31:0] epc,
                               input logic [15:0] epsw, input string tag);
        int b;
        b = push_cnt - 2;
        chk(lg_addr[b % 8] == osp - 4 && lg_word[b % 8] == 1, {tag, " R4 pc slot"}, lg_addr[b % 8], osp - 4);
        chk(lg_data[b % 8] == opc, {tag, " R4 pc data"}, lg_data[b % 8], opc);
        chk(lg_addr[(b+1) % 8] == osp - 8 && lg_word[(b+1) % 8] == 0, {tag, " R4 psw slot"}, lg_addr[(b+1) % 8], osp - 8);
        chk(lg_data[(b+1) % 8] == {16'h0, opsw}, {tag, " R4 psw data"}, lg_data[(b+1) % 8], {16'h0, opsw});
        chk(cpc == epc, {tag, " new pc"}, cpc, epc);
        chk(cpsw == epsw, {tag, " new psw"}, {16'h0, cpsw}, {16'h0, epsw});
        chk(csp == osp - 8, {tag, " new sp"}, csp, osp - 8);
    endtask

    initial begin
        bit got;
        int np, a0, u0c, r0;
        logic [15:0] exp_r, ps;
        logic [31:0] pc0, sp0;

        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!mw_valid && !upd && !ackv && !rtake, "R1 idle outputs", {mw_valid, upd, ackv, rtake}, 0);
        reg_addr = 7'h00; #1;
        chk(rdata == 0, "R1 vector reset", rdata, 0);
        load_core(32'h100, 16'h0F00, 32'h2000);
        repeat (4) @(negedge clk);
        chk(upd_cnt == 0 && push_cnt == 0, "R1 level resets to 7", upd_cnt, 0);

        // R9/R10 program vectors then sweep all offsets
        for (int l = 0; l < 7; l++) begin
            vec_m[l] = 16'h0100 + 16'(l) * 16'h0123;
            reg_write(7'(l * 4), 3'd2, vec_m[l]);
        end
        reg_write(7'h00, 3'd1, 16'hDEAD);  // R10 wrong width
        reg_write(7'h04, 3'd4, 16'hBEEF);  // R10 wrong width
        reg_write(7'h20, 3'd2, 16'h1111);  // R10 read-only
        reg_write(7'h40, 3'd2, 16'h2222);  // R10 read-only
        reg_write(7'h02, 3'd2, 16'h3333);  // R10 unaligned
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            reg_addr = 7'(a); #1;
            if (a % 4 == 0 && a / 4 < 7) exp_r = vec_m[a / 4];
            else if (a == 32'h20)        exp_r = MEMCTL;
            else if (a == 32'h40)        exp_r = CPUMODE;
            else                         exp_r = 16'h0;
            chk(rdata == exp_r, "R9 R10 register read", {16'h0, rdata}, {16'h0, exp_r});
        end

        // R3 R5 R7 R11 acceptance sweep
        for (int ie = 0; ie < 2; ie++)
            for (int m = 0; m < 8; m++)
                for (int l = 0; l < 8; l++) begin
                    pc0 = 32'h1000_0000 + 32'(ie * 64 + m * 8 + l) * 16;
                    sp0 = 32'h2000_0000 + 32'(ie * 64 + m * 8 + l) * 32'h100;
                    ps  = 16'h0005 | (16'(ie) << 11) | (16'(m) << 8);
                    stall = m[0];
                    load_core(pc0, ps, sp0);
                    a0 = ack_cnt;
                    level = 3'(l);
                    wait_entry(12, got, np);
                    chk(got == (ie == 1 && l < m), "R3 accept decision", {31'h0, got}, {31'h0, (ie == 1 && l < m)});
                    if (got) begin
                        chk(np == 2, "R11 two pushes before update", np, 2);
                        check_frame(pc0, ps, sp0, 32'h4000_0000 + {16'h0, vec_m[l]},
                                    (ps & 16'hF0FF) | (16'(l) << 8), "R5");
                        chk(ack_cnt == a0 + 1 && ack_last == 3'(l), "R7 level ack", {29'h0, ack_last}, l);
                    end else begin
                        chk(ack_cnt == a0, "R7 no ack", ack_cnt, a0);
                    end
                    level = 3'd7;
                    @(negedge clk);
                end
        stall = 0;

        // R6 R8 NMI held high serves once, mask kept, no ack
        load_core(32'h0000_ABC0, 16'h0D21, 32'h3000_0000);
        a0 = ack_cnt; u0c = upd_cnt;
        nmi = 1;
        wait_entry(12, got, np);
        chk(got && np == 2, "R6 nmi entry", {31'h0, got}, 1);
        check_frame(32'h0000_ABC0, 16'h0D21, 32'h3000_0000, 32'h4000_0008, 16'h0521, "R6");
        chk(ack_cnt == a0, "R7 nmi gives no ack", ack_cnt, a0);
        load_core(32'h0000_ABC0, 16'h0D21, 32'h3000_0000);
        repeat (20) @(negedge clk);
        chk(upd_cnt == u0c + 1, "R8 held nmi served once", upd_cnt, u0c + 1);
        nmi = 0;
        @(negedge clk);
        nmi = 1;
        wait_entry(12, got, np);
        chk(got, "R8 new nmi edge served", {31'h0, got}, 1);
        nmi = 0;

        // R2 reset beats nmi beats level
        load_core(32'h0000_5000, 16'h0F00, 32'h4000_0000);
        r0 = rtake_cnt; a0 = ack_cnt; u0c = upd_cnt;
        @(negedge clk);
        rst_req = 1; nmi = 1; level = 3'd0;
        wait_entry(12, got, np);
        chk(rtake_cnt == r0 + 1, "R2 reset served", rtake_cnt, r0 + 1);
        chk(got && cpc == 32'h4000_0008, "R2 nmi after reset", cpc, 32'h4000_0008);
        repeat (10) @(negedge clk);
        chk(upd_cnt == u0c + 1 && ack_cnt == a0, "R2 level waits behind nmi", upd_cnt, u0c + 1);
        chk(rtake_cnt == r0 + 1, "R8 held reset served once", rtake_cnt, r0 + 1);
        rst_req = 0; nmi = 0; level = 3'd7;

        // R12 pending level becomes acceptable later
        load_core(32'h0000_6000, 16'h0700, 32'h5000_0000);
        level = 3'd3;
        repeat (10) @(negedge clk);
        u0c = upd_cnt;
        chk(push_cnt % 1 == 0 && !mw_valid, "R12 waits while disabled", {31'h0, mw_valid}, 0);
        load_core(32'h0000_6000, 16'h0F00, 32'h5000_0000);
        wait_entry(12, got, np);
        chk(got && cpc == 32'h4000_0000 + {16'h0, vec_m[3]}, "R12 taken once enabled", cpc, 32'h4000_0000 + {16'h0, vec_m[3]});
        level = 3'd7;
        // withdrawn before acceptable
        load_core(32'h0000_7000, 16'h0700, 32'h5000_0000);
        level = 3'd2;
        repeat (5) @(negedge clk);
        level = 3'd7;
        repeat (3) @(negedge clk);
        u0c = upd_cnt;
        load_core(32'h0000_7000, 16'h0F00, 32'h5000_0000);
        repeat (12) @(negedge clk);
        chk(upd_cnt == u0c, "R12 withdrawn level not taken", upd_cnt, u0c);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule